// File: doc/BRIEF.md
# Pulse Program Flow Verifier

This block checks a pulse-sequencer program held in its own program memory before that program is allowed to run. Once a start pulse arrives, it clears its per-address records and then follows the program from address 0. The program has no conditional branches, so the walk takes exactly one path. Along the way it keeps shadow copies of the subroutine return stack and the loop-start stack. For each address it records whether the address was reached and what the two stack depths were on that first visit.

In checking mode every loop is taken once, so each loop end falls through. Because of this, any revisit of an address means the real program would repeat forever. The depths recorded at the first visit are then compared with the current depths. Equal depths mean a safe endless program. Different depths mean one of the stacks will eventually overflow. After the walk ends, the block scans its records and sends out one pulse for every address that was never reached. It then raises `done` together with a 4-bit exit code and the address where the walk stopped.

A host writes the program through a simple write port while the block is idle. Each instruction word carries a 4-bit opcode in its top bits and an argument below it. The argument is a jump, call or loop-start address; a loop count is unused. Output values and delay lengths are not part of the word.

Top module: `pfv_flow_verifier`

## Requirements
- R1: Reset state: `done`=0 and `status`=0. From the clock edge after `start` until the result is ready, `status` reads 0 (busy) and `done` reads 0. Once `done` is 1, `done`, `status` and `fault_addr` stay unchanged until the next `start`.
- R2: A halt instruction (opcode 1) ends the walk with status 1, and `fault_addr` is the address of that instruction.
- R3: Reaching an already visited address, with both stack depths equal to those recorded there, ends with status 2. `fault_addr` is the revisited address.
- R4: On a revisit, a different subroutine depth gives status 3. Otherwise, a different loop depth gives status 4. `fault_addr` is the revisited address.
- R5: If the next address falls outside the program memory, the walk ends with status 5 and `fault_addr` is the instruction that produced it. This covers three cases: a step past the last word, a return to the last word plus one, and a jump or call argument of 2^ADDR_W or more.
- R6: A call (opcode 5) with MAX_SUB entries already on the subroutine stack gives status 6. A return (opcode 6) on an empty subroutine stack gives status 7. Otherwise a call pushes its own address and jumps to its argument, and a return resumes one word after the popped address.
- R7: A loop start (opcode 2) with MAX_LOOP entries already on the loop stack gives status 8. A loop end (opcode 3) on an empty loop stack gives status 9. Otherwise a loop start pushes its own address and advances.
- R8: A loop end whose argument differs from the popped loop-start address gives status 10. A matching loop end pops and falls through to the next address, so each loop body is walked once. This holds even when the loop end lies below its loop start in memory.
- R9: Continue (0), wait (7), long delay (8) and all unassigned opcodes only advance the address. Goto (4) moves to its argument.
- R10: After the walk, and before `done` rises, `unused_valid` pulses once for each address never reached, with `unused_addr` in ascending order. Addresses that were reached, including the final one, give no pulse.
- R11: Each `start` first clears every visited record, one address per cycle, so a run never depends on an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write enable |
| prog_waddr | input | ADDR_W | Program memory write address |
| prog_wdata | input | ARG_W+4 | Instruction word {opcode[3:0], argument} |
| start | input | 1 | Begin a check (accepted when idle or done) |
| done | output | 1 | Result valid and held |
| status | output | 4 | Exit code (0 while busy) |
| fault_addr | output | ADDR_W | Address where the walk ended |
| unused_valid | output | 1 | One-cycle pulse per never-reached address |
| unused_addr | output | ADDR_W | The never-reached address |

## Verification
The bench builds the block with a 16-word memory (ADDR_W=4), an 8-bit argument and both stacks limited to two entries. This size lets a straight run of plain steps hit the end of memory, and lets three nested calls or three nested loops reach each overflow code. With an 8-bit argument, a jump target of 16 lies outside the memory, so the out-of-range jump case can be tested. Programs run back to back, so stale visited bits from an earlier run would change a later result.

// File: rtl/pfv_pkg.sv
package pfv_pkg;

  typedef enum logic [3:0] {
    OP_CONT    = 4'd0,
    OP_HALT    = 4'd1,
    OP_LOOP    = 4'd2,
    OP_ENDLOOP = 4'd3,
    OP_GOTO    = 4'd4,
    OP_CALL    = 4'd5,
    OP_RET     = 4'd6,
    OP_WAIT    = 4'd7,
    OP_LDELAY  = 4'd8
  } op_e;

  typedef enum logic [3:0] {
    ST_BUSY         = 4'd0,
    ST_HALTED       = 4'd1,
    ST_SPIN_OK      = 4'd2,
    ST_SPIN_CALLGRW = 4'd3,
    ST_SPIN_LOOPGRW = 4'd4,
    ST_OVERRUN      = 4'd5,
    ST_CALL_OVF     = 4'd6,
    ST_RET_UNDER    = 4'd7,
    ST_LOOP_OVF     = 4'd8,
    ST_END_UNDER    = 4'd9,
    ST_END_MISMATCH = 4'd10
  } code_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR,
    S_FETCH,
    S_EXEC,
    S_SCAN,
    S_DONE
  } state_e;

endpackage

// File: rtl/pfv_sdp_ram.sv
module pfv_sdp_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfv_lifo.sv
module pfv_lifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [DW-1:0] slot [DEPTH];

  assign empty = (count == '0);
  assign full  = (count == LIMIT);
  assign top   = empty ? '0 : slot[IW'(count - 1'b1)];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (push && !full) begin
      slot[IW'(count)] <= din;
      count <= count + 1'b1;
    end else if (pop && !empty) begin
      count <= count - 1'b1;
    end
  end

  // R6: the walker never pushes onto a full stack
  p_push_not_full_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R7: the walker never pops an empty stack
  p_pop_not_empty_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  p_one_op_r6: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/pfv_flow_verifier.sv
module pfv_flow_verifier
  import pfv_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int ARG_W    = 16,
  parameter int MAX_SUB  = 8,
  parameter int MAX_LOOP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_waddr,
  input  logic [ARG_W+3:0]  prog_wdata,
  input  logic              start,
  output logic              done,
  output logic [3:0]        status,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              unused_valid,
  output logic [ADDR_W-1:0] unused_addr
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int INSTR_W = ARG_W + 4;
  localparam int SUB_W   = $clog2(MAX_SUB + 1);
  localparam int LOOP_W  = $clog2(MAX_LOOP + 1);
  localparam int INFO_W  = 1 + SUB_W + LOOP_W;
  localparam logic [ADDR_W:0] LAST_CNT = (ADDR_W + 1)'(DEPTH - 1);
  localparam logic [ADDR_W:0] END_CNT  = (ADDR_W + 1)'(DEPTH);

  state_e              state_q;
  logic [ADDR_W-1:0]   pc_q;
  logic [ADDR_W:0]     cnt_q;
  logic                pend_q;
  logic [ADDR_W-1:0]   pend_addr_q;
  code_e               code_q;
  logic [ADDR_W-1:0]   end_pc_q;

  // instruction fetch
  logic [INSTR_W-1:0]  instr;
  op_e                 op;
  logic [ARG_W-1:0]    arg;
  logic [ADDR_W:0]     target;

  pfv_sdp_ram #(.AW(ADDR_W), .DW(INSTR_W)) u_prog (
    .clk(clk), .we(prog_we), .waddr(prog_waddr), .wdata(prog_wdata),
    .raddr(pc_q), .rdata(instr)
  );

  assign op     = op_e'(instr[INSTR_W-1:ARG_W]);
  assign arg    = instr[ARG_W-1:0];
  assign target = {|arg[ARG_W-1:ADDR_W], arg[ADDR_W-1:0]};

  // per-address visit record {visited, sub depth, loop depth}
  logic                info_we;
  logic [ADDR_W-1:0]   info_waddr, info_raddr;
  logic [INFO_W-1:0]   info_wdata, info_rd;
  logic                seen;
  logic [SUB_W-1:0]    seen_sub;
  logic [LOOP_W-1:0]   seen_loop;

  pfv_sdp_ram #(.AW(ADDR_W), .DW(INFO_W)) u_info (
    .clk(clk), .we(info_we), .waddr(info_waddr), .wdata(info_wdata),
    .raddr(info_raddr), .rdata(info_rd)
  );

  assign seen      = info_rd[INFO_W-1];
  assign seen_sub  = info_rd[INFO_W-2 -: SUB_W];
  assign seen_loop = info_rd[LOOP_W-1:0];

  // shadow stacks
  logic                stk_clr;
  logic                sub_push, sub_pop, sub_empty, sub_full;
  logic [ADDR_W-1:0]   sub_top;
  logic [SUB_W-1:0]    sub_cnt;
  logic                lp_push, lp_pop, lp_empty, lp_full;
  logic [ADDR_W-1:0]   lp_top;
  logic [LOOP_W-1:0]   lp_cnt;

  assign stk_clr = (state_q == S_CLEAR);

  pfv_lifo #(.DEPTH(MAX_SUB), .DW(ADDR_W), .CW(SUB_W)) u_sub (
    .clk(clk), .rst(rst), .clr(stk_clr), .push(sub_push), .pop(sub_pop),
    .din(pc_q), .top(sub_top), .count(sub_cnt), .empty(sub_empty),
    .full(sub_full)
  );

  pfv_lifo #(.DEPTH(MAX_LOOP), .DW(ADDR_W), .CW(LOOP_W)) u_loop (
    .clk(clk), .rst(rst), .clr(stk_clr), .push(lp_push), .pop(lp_pop),
    .din(pc_q), .top(lp_top), .count(lp_cnt), .empty(lp_empty),
    .full(lp_full)
  );

  // record write / read steering
  assign info_we    = (state_q == S_CLEAR) || (state_q == S_EXEC && !seen);
  assign info_waddr = (state_q == S_CLEAR) ? cnt_q[ADDR_W-1:0] : pc_q;
  assign info_wdata = (state_q == S_CLEAR) ? '0 : {1'b1, sub_cnt, lp_cnt};
  assign info_raddr = (state_q == S_SCAN) ? cnt_q[ADDR_W-1:0] : pc_q;

  // instruction evaluation
  logic            fin;
  code_e           fin_code;
  logic [ADDR_W:0] nxt;

  always_comb begin
    fin      = 1'b0;
    fin_code = ST_BUSY;
    nxt      = {1'b0, pc_q} + 1'b1;
    sub_push = 1'b0;
    sub_pop  = 1'b0;
    lp_push  = 1'b0;
    lp_pop   = 1'b0;
    if (state_q == S_EXEC) begin
      if (seen) begin
        fin = 1'b1;
        if (seen_sub != sub_cnt)     fin_code = ST_SPIN_CALLGRW;
        else if (seen_loop != lp_cnt) fin_code = ST_SPIN_LOOPGRW;
        else                          fin_code = ST_SPIN_OK;
      end else begin
        case (op)
          OP_HALT: begin
            fin      = 1'b1;
            fin_code = ST_HALTED;
          end
          OP_CALL: begin
            if (sub_full) begin
              fin      = 1'b1;
              fin_code = ST_CALL_OVF;
            end else begin
              sub_push = 1'b1;
              nxt      = target;
            end
          end
          OP_RET: begin
            if (sub_empty) begin
              fin      = 1'b1;
              fin_code = ST_RET_UNDER;
            end else begin
              sub_pop = 1'b1;
              nxt     = {1'b0, sub_top} + 1'b1;
            end
          end
          OP_LOOP: begin
            if (lp_full) begin
              fin      = 1'b1;
              fin_code = ST_LOOP_OVF;
            end else begin
              lp_push = 1'b1;
            end
          end
          OP_ENDLOOP: begin
            if (lp_empty) begin
              fin      = 1'b1;
              fin_code = ST_END_UNDER;
            end else if (ARG_W'(lp_top) != arg) begin
              fin      = 1'b1;
              fin_code = ST_END_MISMATCH;
            end else begin
              lp_pop = 1'b1;
            end
          end
          OP_GOTO: nxt = target;
          default: ;
        endcase
        if (!fin && nxt[ADDR_W]) begin
          fin      = 1'b1;
          fin_code = ST_OVERRUN;
        end
      end
    end
  end

  // control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      pc_q         <= '0;
      cnt_q        <= '0;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      code_q       <= ST_BUSY;
      end_pc_q     <= '0;
      done         <= 1'b0;
      status       <= '0;
      fault_addr   <= '0;
      unused_valid <= 1'b0;
      unused_addr  <= '0;
    end else begin
      unused_valid <= 1'b0;
      case (state_q)
        S_IDLE, S_DONE: begin
          if (start) begin
            state_q    <= S_CLEAR;
            cnt_q      <= '0;
            done       <= 1'b0;
            status     <= '0;
            fault_addr <= '0;
          end
        end
        S_CLEAR: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_CNT) begin
            state_q <= S_FETCH;
            pc_q    <= '0;
          end
        end
        S_FETCH: state_q <= S_EXEC;
        S_EXEC: begin
          if (fin) begin
            code_q   <= fin_code;
            end_pc_q <= pc_q;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            state_q  <= S_SCAN;
          end else begin
            pc_q    <= nxt[ADDR_W-1:0];
            state_q <= S_FETCH;
          end
        end
        S_SCAN: begin
          if (cnt_q != END_CNT) begin
            pend_q      <= 1'b1;
            pend_addr_q <= cnt_q[ADDR_W-1:0];
            cnt_q       <= cnt_q + 1'b1;
          end else begin
            pend_q <= 1'b0;
          end
          unused_valid <= pend_q && !seen;
          unused_addr  <= pend_addr_q;
          if (cnt_q == END_CNT && !pend_q) begin
            state_q    <= S_DONE;
            done       <= 1'b1;
            status     <= code_q;
            fault_addr <= end_pc_q;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: no code shows while busy
  p_busy_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !done |-> status == 4'd0);
  // R1: the result holds until a new start
  p_result_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(status) && $stable(fault_addr)));
  // R2: a finished walk always carries a defined exit code
  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 4'd0 && status <= 4'd10));
  // R3: a revisit always ends the walk
  p_revisit_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_EXEC && seen) |=> state_q == S_SCAN);
  // R10: unreached-address pulses come only before the result
  p_unused_before_done_r10: assert property (@(posedge clk) disable iff (rst)
    unused_valid |-> !done);
endmodule

// File: tb/pfv_flow_verifier_test.sv
module pfv_flow_verifier_test;
  localparam int AW = 4;
  localparam int GW = 8;
  localparam int IW = GW + 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_we = 1'b0;
  logic [AW-1:0] prog_waddr = '0;
  logic [IW-1:0] prog_wdata = '0;
  logic          start = 1'b0;
  logic          done;
  logic [3:0]    status;
  logic [AW-1:0] fault_addr;
  logic          unused_valid;
  logic [AW-1:0] unused_addr;

  pfv_flow_verifier #(.ADDR_W(AW), .ARG_W(GW), .MAX_SUB(2), .MAX_LOOP(2)) uut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_waddr(prog_waddr),
    .prog_wdata(prog_wdata), .start(start), .done(done), .status(status),
    .fault_addr(fault_addr), .unused_valid(unused_valid),
    .unused_addr(unused_addr)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [IW-1:0] img [N];

  int    exp_code_q[$];
  int    exp_fault_q[$];
  string exp_tag_q[$];
  int    exp_unused_q[$];
  string cur_tag = "";
  logic  prev_done = 1'b0;

  function automatic logic [IW-1:0] mk(int op, int a);
    return {op[3:0], a[GW-1:0]};
  endfunction

  task automatic fill(int op);
    for (int a = 0; a < N; a++) img[a] = mk(op, 0);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (unused_valid) begin
        if (exp_unused_q.size() == 0) check({cur_tag, " R10 extra unused"}, int'(unused_addr), -1);
        else check({cur_tag, " R10 unused addr"}, int'(unused_addr), exp_unused_q.pop_front());
      end
      if (done && !prev_done) begin
        if (exp_code_q.size() == 0) begin
          check("R1 unexpected done", 1, 0);
        end else begin
          string t;
          t = exp_tag_q.pop_front();
          check({t, " status"}, int'(status), exp_code_q.pop_front());
          check({t, " fault_addr"}, int'(fault_addr), exp_fault_q.pop_front());
          check({t, " R10 missing unused pulses"}, exp_unused_q.size(), 0);
          exp_unused_q.delete();
        end
      end
    end
    prev_done = done;
  end

  // driver: load program, push expectations, start, wait
  task automatic run(string tag, int code, int fault, logic [N-1:0] vis);
    logic [3:0]    s;
    logic [AW-1:0] f;
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      prog_we = 1'b1;
      prog_waddr = a[AW-1:0];
      prog_wdata = img[a];
    end
    @(negedge clk);
    prog_we = 1'b0;
    cur_tag = tag;
    exp_tag_q.push_back(tag);
    exp_code_q.push_back(code);
    exp_fault_q.push_back(fault);
    for (int a = 0; a < N; a++) if (!vis[a]) exp_unused_q.push_back(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R1 busy done"}, int'(done), 0);
    check({tag, " R1 busy status"}, int'(status), 0);
    while (!done) @(negedge clk);
    s = status;
    f = fault_addr;
    repeat (4) @(negedge clk);
    check({tag, " R1 hold done"}, int'(done), 1);
    check({tag, " R1 hold status"}, int'(status), int'(s));
    check({tag, " R1 hold fault"}, int'(fault_addr), int'(f));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset status", int'(status), 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: straight run off the end, every word reached
    fill(0);
    run("R5 step past end", 5, 15, 16'hFFFF);

    // R9, R11, R2: plain advances, unknown opcode, halt; stale bits must be gone
    fill(1);
    img[0] = mk(0, 0); img[1] = mk(7, 0); img[2] = mk(8, 0);
    img[3] = mk(15, 9); img[4] = mk(1, 0);
    run("R9 R11 R2 advance then halt", 1, 4, 16'h001F);

    // R3: goto back to start
    fill(1);
    img[0] = mk(0, 0); img[1] = mk(4, 0);
    run("R3 safe spin", 2, 0, 16'h0003);

    // R4: recursive call grows subroutine depth
    fill(1);
    img[0] = mk(5, 0);
    run("R4 call growth", 3, 0, 16'h0001);

    // R4: loop start revisited with deeper loop stack
    fill(1);
    img[0] = mk(2, 5); img[1] = mk(4, 0);
    run("R4 loop growth", 4, 0, 16'h0003);

    // R6: third nested call overflows
    fill(1);
    img[0] = mk(5, 2); img[2] = mk(5, 4); img[4] = mk(5, 6);
    run("R6 call overflow", 6, 4, 16'h0015);

    // R6: return without a call
    fill(1);
    img[0] = mk(6, 0);
    run("R6 return underflow", 7, 0, 16'h0001);

    // R7: third nested loop overflows
    fill(1);
    img[0] = mk(2, 1); img[1] = mk(2, 1); img[2] = mk(2, 1);
    run("R7 loop overflow", 8, 2, 16'h0007);

    // R7: loop end without a loop
    fill(1);
    img[0] = mk(3, 0);
    run("R7 endloop underflow", 9, 0, 16'h0001);

    // R8: loop end names the wrong start
    fill(1);
    img[0] = mk(2, 3); img[1] = mk(3, 5);
    run("R8 endloop mismatch", 10, 1, 16'h0003);

    // R6 R8: balanced loop and subroutine then halt
    fill(1);
    img[0] = mk(2, 4); img[1] = mk(5, 5); img[2] = mk(3, 0);
    img[3] = mk(1, 0); img[5] = mk(0, 0); img[6] = mk(6, 0);
    run("R6 R8 balanced", 1, 3, 16'h006F);

    // R8: loop end placed before its own loop start
    fill(1);
    img[0] = mk(2, 3); img[1] = mk(4, 5); img[2] = mk(0, 0);
    img[3] = mk(3, 6); img[4] = mk(1, 0); img[5] = mk(3, 0);
    img[6] = mk(2, 4); img[7] = mk(4, 2);
    run("R8 out of order nesting", 1, 4, 16'h00FF);

    // R5: return lands one past the last word
    fill(1);
    img[0] = mk(4, 15); img[15] = mk(5, 3); img[3] = mk(6, 0);
    run("R5 return past end", 5, 3, 16'h8009);

    // R5: jump argument beyond memory
    fill(1);
    img[0] = mk(4, 16);
    run("R5 jump out of range", 5, 0, 16'h0001);

    // R3 R6: call and return inside an endless loop keep depth
    fill(1);
    img[0] = mk(5, 2); img[1] = mk(4, 0); img[2] = mk(6, 0);
    run("R3 R6 spin with call", 2, 0, 16'h0007);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule